// File: doc/BRIEF.md
# Eight-Function Nibble ALU

This block is a purely combinational arithmetic-logic unit. It takes two 4-bit operands and a 3-bit function select, and it drives an 8-bit result. It builds every candidate result at the same time: two sums, two nibble-split bitwise pairs, two condition detectors and a swap-with-complement. A case-style multiplexer then picks one of them. Result bits that an operation does not fill are driven to zero.

One of the two sums comes from an explicit ripple chain of full-adder instances, with its carry-in tied to zero. The other uses the language's addition operator. The two sums must always agree, which makes the pair a built-in cross-check of the structural adder. The block has no clock and no state. Display decoding, switch wiring and key polarity are handled by the logic around it.

Top module: `nibble_alu`

## Requirements
- R1: Select 0 drives the sum A+B from a chain of four full adders with carry-in 0. The four sum bits go to result[3:0], the carry-out goes to result[4], and result[7:5] is 0.
- R2: Select 1 drives A+B from the addition operator, zero-extended to 8 bits. The structural sum and the operator sum are equal for every operand pair.
- R3: Select 2 drives A NOR B on result[7:4] and A NAND B on result[3:0].
- R4: Select 3 drives 8'hC0 when any of the eight operand bits is 1, and 8'h00 when all of them are 0. The test is a single OR reduction over both operands.
- R5: Select 4 drives 8'h3F when A has exactly two bits set and B has exactly three bits set, and 8'h00 otherwise.
- R6: Select 5 drives B on result[7:4] and the whole-nibble complement of A on result[3:0].
- R7: Select 6 drives A XOR B on result[7:4] and A XNOR B on result[3:0].
- R8: Select 7 falls to the default branch and drives 8'h00, so every select value assigns the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 4 | Operand A |
| opb | input | 4 | Operand B |
| fsel | input | 3 | Function select, 0 to 7 |
| result | output | 8 | Selected function result |

## Verification
The hardest case to reach is the select-4 detector. Only 24 of the 256 operand pairs meet its condition: six values of A have exactly two bits set, and four values of B have exactly three. The bench therefore sweeps every operand pair under every select value, so each of those 24 hits, and the misses beside them, is checked.

The carry into bit 4 under select 0 is reached by the same sweep. That includes the all-ones pair 15+15, which carries through every stage of the ripple chain.

// File: rtl/nibble_alu_pkg.sv
package nibble_alu_pkg;

  typedef enum logic [2:0] {
    FN_RIPPLE_ADD = 3'd0,
    FN_OPER_ADD   = 3'd1,
    FN_NAND_NOR   = 3'd2,
    FN_ANY_SET    = 3'd3,
    FN_POP_MATCH  = 3'd4,
    FN_SWAP_INV   = 3'd5,
    FN_XNOR_XOR   = 3'd6,
    FN_UNUSED     = 3'd7
  } alu_fn_e;

endpackage

// File: rtl/nib_full_adder.sv
module nib_full_adder (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic half;
  assign half = a ^ b;
  assign s    = half ^ ci;
  assign co   = (a & b) | (ci & half);
endmodule

// File: rtl/nib_ripple_adder.sv
module nib_ripple_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] carry;
  assign carry[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_stage
    nib_full_adder u_fa (
      .a (a[i]),
      .b (b[i]),
      .ci(carry[i]),
      .s (s[i]),
      .co(carry[i+1])
    );
  end

  assign co = carry[W];

  // R1: the chain's output matches arithmetic addition of its inputs
  always_comb begin
    assert_chain_sum_R1: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci}))
      else $error("ripple chain sum wrong");
  end
endmodule

// File: rtl/nibble_alu.sv
module nibble_alu
  import nibble_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  logic [2:0]     fsel,
  output logic [2*W-1:0] result
);
  localparam int RW = 2 * W;
  localparam int A_ONES = 2;
  localparam int B_ONES = 3;
  localparam logic [RW-1:0] ANY_PAT = {2'b11, {(RW-2){1'b0}}};
  localparam logic [RW-1:0] POP_PAT = {2'b00, {(RW-2){1'b1}}};

  logic [W-1:0]  rip_sum;
  logic          rip_co;
  logic [RW-1:0] cand_rip, cand_op, cand_nn, cand_any, cand_pop, cand_swp, cand_xx;

  nib_ripple_adder #(.W(W)) u_rip (
    .a (opa),
    .b (opb),
    .ci(1'b0),
    .s (rip_sum),
    .co(rip_co)
  );

  assign cand_rip = {{(RW-W-1){1'b0}}, rip_co, rip_sum};
  assign cand_op  = {{W{1'b0}}, opa} + {{W{1'b0}}, opb};
  assign cand_nn  = {~(opa | opb), ~(opa & opb)};
  assign cand_any = (|{opa, opb}) ? ANY_PAT : '0;
  assign cand_pop = (($countones(opa) == A_ONES) && ($countones(opb) == B_ONES)) ? POP_PAT : '0;
  assign cand_swp = {opb, ~opa};
  assign cand_xx  = {opa ^ opb, ~(opa ^ opb)};

  always_comb begin
    case (alu_fn_e'(fsel))
      FN_RIPPLE_ADD: result = cand_rip;
      FN_OPER_ADD:   result = cand_op;
      FN_NAND_NOR:   result = cand_nn;
      FN_ANY_SET:    result = cand_any;
      FN_POP_MATCH:  result = cand_pop;
      FN_SWAP_INV:   result = cand_swp;
      FN_XNOR_XOR:   result = cand_xx;
      default:       result = '0;
    endcase
  end

  always_comb begin
    assert_sums_agree_R2: assert (cand_rip == cand_op)
      else $error("structural and operator sums differ");
    if (fsel == 3'd0) begin
      assert_add_upper_zero_R1: assert (result[RW-1:W+1] == '0)
        else $error("sum upper bits not zero");
    end
    if (fsel == 3'd2) begin
      assert_nor_within_nand_R3: assert ((result[RW-1:W] & ~result[W-1:0]) == '0)
        else $error("NOR half not subset of NAND half");
    end
    if (fsel == 3'd3) begin
      assert_any_zero_in_R4: assert (!((opa == '0) && (opb == '0)) || (result == '0))
        else $error("detector fired on zero operands");
    end
    if (fsel == 3'd4) begin
      assert_pop_shape_R5: assert ((result == '0) || (result == POP_PAT))
        else $error("pop detector gave illegal value");
    end
    if (fsel == 3'd5) begin
      assert_swap_high_R6: assert (result[RW-1:W] == opb)
        else $error("swap high half wrong");
    end
    if (fsel == 3'd6) begin
      assert_xor_pair_R7: assert ((result[RW-1:W] ^ result[W-1:0]) == {W{1'b1}})
        else $error("XOR and XNOR halves not complementary");
    end
    if (fsel == 3'd7) begin
      assert_default_zero_R8: assert (result == '0)
        else $error("default branch not zero");
    end
  end
endmodule

// File: tb/tb_nibble_alu.sv
module tb_nibble_alu;
  logic       clk = 1'b0;
  logic [3:0] opa, opb;
  logic [2:0] fsel;
  logic [7:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    logic [7:0] exp;
    logic [2:0] fs;
    logic [3:0] a;
    logic [3:0] b;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  nibble_alu dut (.opa(opa), .opb(opb), .fsel(fsel), .result(result));

  function automatic int ones(input logic [3:0] v);
    int n = 0;
    for (int i = 0; i < 4; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic logic [7:0] model(input logic [2:0] f, input logic [3:0] a, input logic [3:0] b);
    int sum;
    case (f)
      3'd0, 3'd1: begin sum = int'(a) + int'(b); return 8'(sum); end
      3'd2: return {~(a | b), ~(a & b)};
      3'd3: return ((a != 0) || (b != 0)) ? 8'hC0 : 8'h00;
      3'd4: return ((ones(a) == 2) && (ones(b) == 3)) ? 8'h3F : 8'h00;
      3'd5: return {b, 4'hF - a};
      3'd6: return {a ^ b, ~(a ^ b)};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] f);
    case (f)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic drive(input logic [2:0] f, input logic [3:0] a, input logic [3:0] b);
    item_t it;
    @(negedge clk);
    fsel = f; opa = a; opb = b;
    it.exp = model(f, a, b); it.fs = f; it.a = a; it.b = b;
    sb_q.push_back(it);
  endtask

  // monitor: compare half a cycle after each drive
  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_cmp++;
      if (result !== it.exp) begin
        n_bad++;
        $display("FAIL %s fsel=%0d a=%h b=%h actual=%h expected=%h",
                 req_of(it.fs), it.fs, it.a, it.b, result, it.exp);
      end
    end
  end

  initial begin
    fsel = 3'd7; opa = 4'h0; opb = 4'h0;
    drive(3'd7, 4'h0, 4'h0);   // idle-state check, R8
    drive(3'd0, 4'hF, 4'hF);   // R1 full carry ripple: 8'h1E
    drive(3'd1, 4'hF, 4'h1);   // R2 carry into bit 4: 8'h10
    drive(3'd3, 4'h0, 4'h0);   // R4 all zero -> 00
    drive(3'd4, 4'h3, 4'h7);   // R5 hit -> 3F
    drive(3'd4, 4'h7, 4'h7);   // R5 miss -> 00
    drive(3'd7, 4'hF, 4'hF);   // R8 default ignores operands
    for (int f = 0; f < 8; f++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          drive(3'(f), 4'(a), 4'(b));   // R1..R8 exhaustive sweep, covers R3 R6 R7
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule